// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Comparator

This block holds two time-of-day alarms and compares them against the live BCD time of a calendar counter, which sits outside the block and presents its current seconds, minutes, hours, weekday and day of month as ports together with a one-cycle pulse per second. The first alarm compares seconds, minutes, hours and a day field. The second alarm compares minutes, hours and a day field, and is only considered at the top of a minute. Every alarm field has its own mask bit. A masked field always counts as equal, so the set of masked fields decides how often an alarm fires: once a second, once a minute, once an hour, once a day or once a week/month. A bit in each day field selects whether that field is compared with the weekday or with the day of month.

A match sets a sticky per-alarm flag. The host clears a flag by writing 0 to its status bit; writing 1 leaves it unchanged. Two active-low interrupt lines are derived from the flags and the per-alarm enables. A routing bit either gives each alarm its own line, or merges both alarms onto the first line and passes an external square wave through the second. The host writes registers over a simple one-cycle write port; the bus interface that produces those writes is outside the block.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset both flags are 0, all alarm words and control bits are 0, `irq_a_n` is 1 and `irq_b_n` follows `sqw_in`.
- R2: With write addresses 0 to 3 holding alarm 1 seconds, minutes, hours and day word (mask in bit 7), a `tick` in a cycle where every unmasked field equals the live time sets flag bit 0 at that clock edge; a single differing field prevents it.
- R3: A field with bit 7 set always counts as matching; with bit 7 set in all four alarm 1 words, every `tick` sets flag bit 0.
- R4: In a day word (addresses 3 and 6), bit 6 = 1 compares bits 3:0 with `live_wday`; bit 6 = 0 compares bits 5:0 with `live_mday`.
- R5: Alarm 2 (addresses 4 to 6: minutes, hours, day word) sets flag bit 1 on a matching `tick` only when `live_sec` is 00.
- R6: Hours are compared on bits 6:0, so the 12/24 select (bit 6) and the AM/PM bit (bit 5) must agree as well as the hour digits.
- R7: Writing address 8 clears each flag whose data bit (bit 0 alarm 1, bit 1 alarm 2) is 0 and keeps each whose bit is 1; a match in the same cycle as a clearing write leaves the flag set.
- R8: Without `tick`, a matching time never sets a flag.
- R9: With control word (address 7) bit 2 = 1, `irq_a_n` is low exactly when flag 0 and enable bit 0 are both set, and `irq_b_n` is low exactly when flag 1 and enable bit 1 are both set.
- R10: With control bit 2 = 0, `irq_a_n` is low when either alarm has its flag and enable set, and `irq_b_n` equals `sqw_in`.
- R11: Enable bits gate only the interrupt lines; flags set whether or not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second from the calendar counter |
| live_sec | input | 7 | Live seconds, BCD |
| live_min | input | 7 | Live minutes, BCD |
| live_hour | input | 7 | Live hours with 12/24 bit 6 and AM/PM bit 5 |
| live_wday | input | 3 | Live weekday 1 to 7 |
| live_mday | input | 6 | Live day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| sqw_in | input | 1 | Square wave to pass through in merged mode |
| flags | output | 2 | Sticky alarm flags, bit 0 alarm 1, bit 1 alarm 2 |
| irq_a_n | output | 1 | First active-low interrupt |
| irq_b_n | output | 1 | Second active-low interrupt or square wave |

## Verification
The hardest case to reach is a match that lands in the same clock cycle as a host write that clears the flag, since both the tick and the write must be placed on one edge; the bench drives the write strobe and the tick together in one task. Also awkward is the second alarm seeing a full match of minutes, hours and day while seconds are not 00; the bench holds that time and ticks, then moves only the seconds to 00 and ticks again.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_WORDS = 7;
  localparam logic [AW-1:0] ADDR_CTRL = 4'd7;
  localparam logic [AW-1:0] ADDR_STAT = 4'd8;
  localparam int MASK_BIT = 7;
  localparam int DAYSEL_BIT = 6;

  // One time field: masked, or equal on the low seven bits.
  function automatic logic field_hit(input logic [DW-1:0] aword, input logic [6:0] live);
    return aword[MASK_BIT] | (aword[6:0] == live);
  endfunction

  // Day word: masked, weekday compare, or day-of-month compare.
  function automatic logic day_hit(input logic [DW-1:0] aword, input logic [2:0] wday,
                                   input logic [5:0] mday);
    if (aword[MASK_BIT]) return 1'b1;
    if (aword[DAYSEL_BIT]) return aword[3:0] == {1'b0, wday};
    return aword[5:0] == mday;
  endfunction
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
(
  input  logic [DW-1:0] a_sec,
  input  logic [DW-1:0] a_min,
  input  logic [DW-1:0] a_hour,
  input  logic [DW-1:0] a_day,
  input  logic [6:0]    live_sec,
  input  logic [6:0]    live_min,
  input  logic [6:0]    live_hour,
  input  logic [2:0]    live_wday,
  input  logic [5:0]    live_mday,
  output logic          hit
);
  logic sec_ok, min_ok, hour_ok, day_ok;
  assign sec_ok  = field_hit(a_sec, live_sec);
  assign min_ok  = field_hit(a_min, live_min);
  assign hour_ok = field_hit(a_hour, live_hour);
  assign day_ok  = day_hit(a_day, live_wday, live_mday);
  assign hit = sec_ok & min_ok & hour_ok & day_ok;
endmodule

// File: rtl/irq_route.sv
module irq_route (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] flag,
  input  logic [1:0] ie,
  input  logic       split,
  input  logic       sqw_in,
  output logic       irq_a_n,
  output logic       irq_b_n
);
  logic [1:0] live_irq;
  assign live_irq = flag & ie;
  assign irq_a_n = split ? ~live_irq[0] : ~(|live_irq);
  assign irq_b_n = split ? ~live_irq[1] : sqw_in;

  // R11: an interrupt line only goes low while its flag is held
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_a_n) |-> (|flag));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    live_sec,
  input  logic [6:0]    live_min,
  input  logic [6:0]    live_hour,
  input  logic [2:0]    live_wday,
  input  logic [5:0]    live_mday,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sqw_in,
  output logic [1:0]    flags,
  output logic          irq_a_n,
  output logic          irq_b_n
);
  logic [DW-1:0] aword [NUM_WORDS];
  logic [2:0] ctrl;
  logic [NUM_ALARMS-1:0] flag_q, hit, keep, set_ev;
  logic stat_wr;

  genvar g;
  generate
    for (g = 0; g < NUM_ALARMS; g++) begin : g_alarm
      localparam int BASE = (g == 0) ? 0 : 3;
      logic [DW-1:0] sec_word;
      // Alarm 2 has no seconds word: a fixed 00 compare restricts it to minute tops.
      if (g == 0) begin : g_sec
        assign sec_word = aword[0];
      end else begin : g_nosec
        assign sec_word = '0;
      end
      alarm_cmp u_cmp (
        .a_sec(sec_word), .a_min(aword[BASE+1]), .a_hour(aword[BASE+2]),
        .a_day(aword[BASE+3]), .live_sec(live_sec), .live_min(live_min),
        .live_hour(live_hour), .live_wday(live_wday), .live_mday(live_mday),
        .hit(hit[g]));
    end
  endgenerate

  assign stat_wr = wr_en && (wr_addr == ADDR_STAT);
  assign keep    = stat_wr ? wr_data[NUM_ALARMS-1:0] : '1;
  assign set_ev  = hit & {NUM_ALARMS{tick}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) aword[i] <= '0;
      ctrl   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en) begin
        if (wr_addr < AW'(NUM_WORDS)) aword[wr_addr[2:0]] <= wr_data;
        else if (wr_addr == ADDR_CTRL) ctrl <= wr_data[2:0];
      end
      flag_q <= (flag_q & keep) | set_ev;
    end
  end

  assign flags = flag_q;

  irq_route u_route (
    .clk(clk), .rst_n(rst_n), .flag(flag_q), .ie(ctrl[1:0]), .split(ctrl[2]),
    .sqw_in(sqw_in), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

  // R7: a flag only drops after a status write with its bit at 0
  a_r7_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(wr_en && wr_addr == ADDR_STAT && !wr_data[0]));
  a_r7_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(wr_en && wr_addr == ADDR_STAT && !wr_data[1]));
  // R8: a flag only rises on a second tick
  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~$past(flag_q))) |-> $past(tick));
  // R5: alarm 2 only rises at second 00
  a_r5_top_of_minute: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(live_sec == 7'h00));
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, sqw_in = 0;
  logic [6:0] live_sec = 0, live_min = 0, live_hour = 0;
  logic [2:0] live_wday = 1;
  logic [5:0] live_mday = 1;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] flags;
  logic irq_a_n, irq_b_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_time(input logic [6:0] s, m, h, input logic [2:0] wd, input logic [5:0] md);
    @(negedge clk); live_sec = s; live_min = m; live_hour = h; live_wday = wd; live_mday = md;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(posedge clk); #1;
    @(negedge clk); tick = 0;
  endtask

  task automatic clear_all(); wr(4'd8, 8'h00); endtask

  task automatic t_reset();
    chk("R1 flags", flags, 0);
    chk("R1 irq_a", irq_a_n, 1);
    sqw_in = 1; #1; chk("R1 irq_b follows sqw", irq_b_n, 1);
    sqw_in = 0; #1; chk("R1 irq_b follows sqw", irq_b_n, 0);
  endtask

  task automatic t_match();
    wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12);
    set_time(7'h31, 7'h15, 7'h08, 3'd2, 6'h12);
    do_tick(); chk("R2 sec mismatch", flags[0], 0);
    set_time(7'h30, 7'h15, 7'h08, 3'd2, 6'h12);
    repeat (4) @(negedge clk);
    chk("R8 no tick no flag", flags[0], 0);
    do_tick(); chk("R2 full match", flags[0], 1);
    chk("R11 flag set, irq disabled", irq_a_n, 1);
    clear_all(); chk("R7 clear", flags[0], 0);
  endtask

  task automatic t_daysel();
    wr(3, 8'h43);
    set_time(7'h30, 7'h15, 7'h08, 3'd3, 6'h20);
    do_tick(); chk("R4 weekday match", flags[0], 1);
    clear_all();
    set_time(7'h30, 7'h15, 7'h08, 3'd4, 6'h03);
    do_tick(); chk("R4 weekday mismatch", flags[0], 0);
    wr(3, 8'h03);
    do_tick(); chk("R4 date match", flags[0], 1);
    clear_all();
  endtask

  task automatic t_hour();
    wr(2, 8'h48); wr(3, 8'h80);
    set_time(7'h30, 7'h15, 7'h08, 3'd1, 6'h01);
    do_tick(); chk("R6 12h vs 24h", flags[0], 0);
    set_time(7'h30, 7'h15, 7'h68, 3'd1, 6'h01);
    do_tick(); chk("R6 PM vs AM", flags[0], 0);
    set_time(7'h30, 7'h15, 7'h48, 3'd1, 6'h01);
    do_tick(); chk("R6 12h AM match", flags[0], 1);
    clear_all();
  endtask

  task automatic t_mask();
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    set_time(7'h07, 7'h44, 7'h23, 3'd6, 6'h29);
    do_tick(); chk("R3 all masked", flags[0], 1);
    clear_all();
    set_time(7'h59, 7'h01, 7'h02, 3'd7, 6'h31);
    do_tick(); chk("R3 all masked again", flags[0], 1);
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h03); wr(3, 8'h04);
    clear_all();
  endtask

  task automatic t_alarm2();
    wr(4, 8'h15); wr(5, 8'h08); wr(6, 8'h12);
    set_time(7'h30, 7'h15, 7'h08, 3'd1, 6'h12);
    do_tick(); chk("R5 not at second 00", flags[1], 0);
    set_time(7'h00, 7'h15, 7'h08, 3'd1, 6'h12);
    do_tick(); chk("R5 at second 00", flags[1], 1);
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    do_tick(); chk("R2 both set", flags, 3);
    wr(4'd8, 8'h01); chk("R7 keep bit0 clear bit1", flags, 1);
    wr(4'd8, 8'h02); chk("R7 clear bit0 keep bit1", flags, 0);
    // match and clearing write on one edge
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 4'd8; wr_data = 8'h00;
    @(posedge clk); #1;
    @(negedge clk); tick = 0; wr_en = 0;
    chk("R7 set wins over clear", flags, 3);
  endtask

  task automatic t_route();
    wr(4'd8, 8'h01);                   // flag0 only
    wr(7, 8'h07);
    chk("R9 a from alarm1", irq_a_n, 0); chk("R9 b idle", irq_b_n, 1);
    wr(7, 8'h04);
    chk("R11 disabled a", irq_a_n, 1);
    do_tick(); wr(4'd8, 8'h02);        // flag1 only
    wr(7, 8'h07);
    chk("R9 a idle", irq_a_n, 1); chk("R9 b from alarm2", irq_b_n, 0);
    wr(7, 8'h03);
    chk("R10 a from alarm2", irq_a_n, 0);
    sqw_in = 1; #1; chk("R10 b is sqw", irq_b_n, 1);
    sqw_in = 0; #1; chk("R10 b is sqw", irq_b_n, 0);
    wr(7, 8'h01);
    chk("R10 alarm2 not enabled", irq_a_n, 1);
    chk("R11 flag kept", flags, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1; t_reset();
    #(CLK_PERIOD * 2); @(negedge clk); rst_n = 1;
    t_match();
    t_daysel();
    t_hour();
    t_mask();
    t_alarm2();
    t_route();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule